// File: doc/BRIEF.md
# GPIO Input Event Interrupt Controller

This block watches a parameterised group of input pins and turns level transitions into latched events and a single interrupt line. Every pin first crosses a two-stage synchronizer. Each pin is then compared with its own value from the previous clock. Two configuration bits per pin choose the events to detect:
- a detect-kind bit selects single-edge detection (0) or change detection (1);
- a polarity bit selects the edge used in single-edge mode.

A detected event sets the pin's bit in a pending register. The interrupt line is raised when a pending bit meets a set bit in the enable register.

Software reaches the block through a plain synchronous register port. The port uses a write strobe and a read strobe with a word offset. It always accepts the access, so it has no back-pressure and no valid/ready handshake. Read data appears on `reg_rdata_o` in the cycle after the read strobe and holds until the next read. The offsets are:

| Offset | Register | Access |
|---|---|---|
| 0 | interrupt enable | read/write |
| 1 | detect kind | read/write |
| 2 | polarity | read/write |
| 3 | pending | write 1 to clear |
| 4 | synchronized pin levels | read only |

Register bits at and above NPINS are not stored and read as zero. The port is input only; its direction cannot be changed at run time.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset, the enable, detect-kind, polarity and pending registers read as zero, and `irq_o` is low.
- R2: With detect kind 0 and polarity 0, a 0-to-1 transition of a pin sets its pending bit. A 1-to-0 transition does not set it.
- R3: With detect kind 0 and polarity 1, a 1-to-0 transition sets the pending bit. A 0-to-1 transition does not set it.
- R4: With detect kind 1, every transition sets the pending bit, and the polarity bit has no effect.
- R5: An event sets its pending bit whatever the enable bit holds. `irq_o` is high only while some bit is both pending and enabled.
- R6: Writing offset 3 clears each pending bit whose write-data bit is 1. Pending bits written with 0 keep their value.
- R7: If an event and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R8: `irq_o` is registered. It changes one cycle after the pending-and-enabled condition changes, so it falls one cycle after the clearing write.
- R9: Offset 4 returns the synchronized pin levels in bits NPINS-1:0. The bits above read as zero, and writes to offset 4 are ignored.
- R10: Only bits NPINS-1:0 of the enable, detect-kind and polarity registers are stored. The upper bits read as zero, and offsets 5 to 7 read as zero.
- R11: Read data is registered and valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous input pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks every combination of detect kind, polarity and transition direction. A detector that ignored the polarity bit, or that treated change mode as a single edge, would leave a pending bit wrong in at least one row. One directed test times a clearing write to land in the same cycle as an event, so a design where the clear wins would drop that event. Other directed tests cover:
- a write of zeros to the pending register, which a plain store would turn into a clear of everything;
- the cycle in which the interrupt falls, which an unregistered output would move one cycle early;
- an event on a disabled pin, which must not raise the interrupt until its enable bit is set.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE = 3'd0,
    SEL_KIND   = 3'd1,
    SEL_POL    = 3'd2,
    SEL_PEND   = 3'd3,
    SEL_LEVEL  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] level_prev_o
);
  logic [NPINS-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      level_prev_o <= '0;
    end else begin
      chain_q[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      level_prev_o <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] level_prev_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] evt_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = level_i[g] & ~level_prev_i[g];
    assign fall = ~level_i[g] & level_prev_i[g];
    always_comb begin
      if (kind_i[g]) evt_o[g] = rise | fall;
      else if (pol_i[g]) evt_o[g] = fall;
      else evt_o[g] = rise;
    end
  end
endmodule

// File: rtl/gpio_evt_regs.sv
`timescale 1ns/1ps
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NPINS-1:0]  evt_i,
  input  logic [NPINS-1:0]  level_i,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  kind_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  pend_o,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] pend_d;
  logic [DW-1:0]    rd_mux;

  assign wbits = wdata_i[NPINS-1:0];

  if (NPINS < DW) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DW-1:NPINS];
  end

  assign clr_mask = (wr_i && addr_i == SEL_PEND) ? wbits : '0;
  // A new event overrides a same-cycle clear.
  assign pend_d = (pend_o & ~clr_mask) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      kind_o <= '0;
      pol_o  <= '0;
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= |(pend_o & en_o);
      if (wr_i) begin
        unique case (addr_i)
          SEL_ENABLE: en_o   <= wbits;
          SEL_KIND:   kind_o <= wbits;
          SEL_POL:    pol_o  <= wbits;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      SEL_ENABLE: rd_mux = DW'(en_o);
      SEL_KIND:   rd_mux = DW'(kind_o);
      SEL_POL:    rd_mux = DW'(pol_o);
      SEL_PEND:   rd_mux = DW'(pend_o);
      SEL_LEVEL:  rd_mux = DW'(level_i);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_evt_ctrl.sv
`timescale 1ns/1ps
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] level_w, level_prev_w;
  logic [NPINS-1:0] kind_w, pol_w, en_w, pend_w, evt_w;

  gpio_evt_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pins_i       (pins_i),
    .level_o      (level_w),
    .level_prev_o (level_prev_w)
  );

  gpio_evt_detect #(.NPINS(NPINS)) u_detect (
    .level_i      (level_w),
    .level_prev_i (level_prev_w),
    .kind_i       (kind_w),
    .pol_i        (pol_w),
    .evt_o        (evt_w)
  );

  gpio_evt_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt_w),
    .level_i (level_w),
    .en_o    (en_w),
    .kind_o  (kind_w),
    .pol_o   (pol_w),
    .pend_o  (pend_w),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gpio_evt_chk.sv
`timescale 1ns/1ps
module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [NPINS-1:0]  en,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  evt,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata
);
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en)) |=> irq); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq); // R5

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == SEL_PEND) |=> ((pend & $past(pend)) == $past(pend))); // R6

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R7

  if (NPINS < DW) begin : g_hi
    AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DW-1:NPINS] == '0); // R10
  end
endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .irq   (irq_o),
  .en    (en_w),
  .pend  (pend_w),
  .evt   (evt_w),
  .wr    (reg_wr_i),
  .addr  (reg_addr_i),
  .rdata (reg_rdata_o)
);

// File: tb/tb_gpio_evt_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_evt_ctrl;
  localparam int NPINS = 8;
  localparam int DW    = 32;
  localparam logic [2:0] A_EN = 3'd0, A_KIND = 3'd1, A_POL = 3'd2,
                         A_PEND = 3'd3, A_LVL = 3'd4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins = '0;
  logic             wr = 1'b0, rd = 1'b0;
  logic [2:0]       addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [DW-1:0]    rdata;
  logic             irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_ctrl #(.NPINS(NPINS), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {kind, pol, from, to, expected pending}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_1_1, 5'b0_0_1_0_0, 5'b0_1_1_0_1, 5'b0_1_0_1_0,
    5'b1_0_0_1_1, 5'b1_0_1_0_1, 5'b1_1_0_1_1, 5'b1_1_1_0_1
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    reg_read(A_EN, v);   check("R1 enable", v, 32'd0);
    reg_read(A_KIND, v); check("R1 kind", v, 32'd0);
    reg_read(A_POL, v);  check("R1 polarity", v, 32'd0);
    reg_read(A_PEND, v); check("R1 pending", v, 32'd0);

    // Table walk on pin 0: R2, R3, R4
    for (int i = 0; i < 8; i++) begin
      string tag;
      logic [4:0] e;
      e = VEC[i];
      tag = e[4] ? "R4" : (e[3] ? "R3" : "R2");
      reg_write(A_KIND, {31'd0, e[4]});
      reg_write(A_POL, {31'd0, e[3]});
      pins[0] = e[2];
      idle(4);
      reg_write(A_PEND, '1);
      pins[0] = e[1];
      idle(4);
      reg_read(A_PEND, v);
      check(tag, v, {31'd0, e[0]});
    end
    reg_write(A_KIND, '0);
    reg_write(A_POL, '0);
    pins = '0;
    idle(4);
    reg_write(A_PEND, '1);

    // R5 pending without enable, irq stays low
    pins[1] = 1'b1;
    idle(5);
    reg_read(A_PEND, v);
    check("R5 pending set while disabled", v, 32'h2);
    check("R5 irq low while disabled", {31'd0, irq}, 32'd0);
    reg_write(A_EN, 32'h2);
    idle(1);
    check("R5 irq after enable", {31'd0, irq}, 32'd1);

    // R6 writing zeros keeps pending
    reg_write(A_PEND, 32'h0);
    reg_read(A_PEND, v);
    check("R6 zero write keeps", v, 32'h2);
    // R8 clear of bit 1: irq still high right after, low one cycle later
    reg_write(A_PEND, 32'h2);
    check("R8 irq one cycle after clear", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8 irq dropped", {31'd0, irq}, 32'd0);
    reg_read(A_PEND, v);
    check("R6 bit cleared", v, 32'h0);

    // R7 event and clear land in the same cycle
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = A_PEND; wdata = 32'h4;
    @(negedge clk); wr = 1'b0;
    reg_read(A_PEND, v);
    check("R7 set wins", v, 32'h4);

    // R9 pin levels, writes ignored
    pins = 8'hA5;
    idle(4);
    reg_read(A_LVL, v);
    check("R9 levels", v, 32'h0000_00A5);
    reg_write(A_LVL, 32'hFFFF_FFFF);
    reg_read(A_LVL, v);
    check("R9 write ignored", v, 32'h0000_00A5);

    // R10 width and unmapped offsets; R11 latency via read timing
    reg_write(A_KIND, 32'hFFFF_FF3C);
    reg_read(A_KIND, v);
    check("R10 kind upper bits", v, 32'h0000_003C);
    reg_read(3'd6, v);
    check("R10 unmapped offset", v, 32'h0);
    @(negedge clk); rd = 1'b1; addr = A_LVL;
    @(negedge clk); rd = 1'b0; addr = A_EN;
    check("R11 data one cycle after strobe", rdata, 32'h0000_00A5);
    @(negedge clk);
    check("R11 data held without strobe", rdata, 32'h0000_00A5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule